// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose pin controller. The pin count is a parameter and must be a multiple of 32. Software reaches the block over a simple synchronous register bus, which carries a byte address, a write strobe, write data and registered read data. The pin side has three vectors: a sampled input vector, an output value vector and an output-enable vector. A further vector carries a 2-bit function selector for each pin. Logic elsewhere on the chip uses that selector to route the pin.

The register space is split into eight banks, one after another. Each bank holds one 32-bit word per 32 pins, and the function-select bank holds twice that. Software changes output values only through two write-one strobe banks, one to set bits and one to clear them. This means a driver never needs a read-modify-write to change one pin. Three banks are kept free in the map for a separate edge-detect block. The level bank shows the pin inputs after a two-stage synchroniser.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NW = NUM_PINS/32, bank b word w lives at byte address (b*NW + w)*4. The bank order is: 0 level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge-status, 7 function-select. The bit for pin p is p%32 of word p/32. Read data is registered and shows the word addressed at the previous rising edge.
- R2: The level bank returns pin_in after two synchroniser flops. A change on pin_in before edge k appears on bus_rdata after edge k+2. Writes to this bank change nothing.
- R3: A direction bit of 1 drives pin_oe high for that pin, and 0 makes the pin an input. The direction bank reads back its stored value.
- R4: Writing the set bank makes pin_out high for every 1 bit and leaves the pins at 0 bits unchanged. The set bank reads as 0.
- R5: Writing the clear bank makes pin_out low for every 1 bit and leaves the pins at 0 bits unchanged. The clear bank reads as 0.
- R6: The function-select bank spans 2*NW words that start at bank 7. Pin p uses word p/16, bits (p%16)*2+1 down to (p%16)*2. That field is driven on pin_alt[2p+1:2p], and the bank reads back its stored value.
- R7: The following read as 0 and ignore writes: banks 4 to 6, addresses past the end of the function-select bank, and addresses whose two low bits are nonzero.
- R8: A synchronous active-high reset clears direction, output value, function select and read data. After reset every pin is a plain input with selector 0.
- R9: A write changes pin_out, pin_oe or pin_alt at the same rising edge that samples it. The ports hold their value in every cycle that has no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_alt | output | 2*NUM_PINS | 2-bit function selector per pin |

## Verification
Register reads are due one edge after the address is presented. Pin-port effects of a write are due at the edge that samples the write. A level change on the pins reaches read data three edges after it is applied. Each driver task stores the due cycle with its expected word, counted from a bench cycle counter that advances on every rising edge. The monitor compares each entry in the cycle it falls due, at the falling edge. An entry that is still pending after its cycle has passed is reported as a failure.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int SUB_W = 8;

    typedef enum logic [2:0] {
        BK_LEVEL = 3'd0,
        BK_DIR   = 3'd1,
        BK_SET   = 3'd2,
        BK_CLR   = 3'd3,
        BK_RISE  = 3'd4,
        BK_FALL  = 3'd5,
        BK_EDGE  = 3'd6,
        BK_ALT   = 3'd7
    } bank_e;

    typedef struct packed {
        logic             hit;
        bank_e            bank;
        logic [SUB_W-1:0] sub;
    } dec_t;

    // Word index -> bank and word within bank; the last bank is twice as long.
    function automatic dec_t decode_word(int unsigned widx, int unsigned nw);
        dec_t d;
        int unsigned b;
        b = widx / nw;
        d.hit  = 1'b0;
        d.bank = BK_LEVEL;
        d.sub  = '0;
        if (b < 7) begin
            d.hit  = 1'b1;
            d.bank = bank_e'(b[2:0]);
            d.sub  = SUB_W'(widx - b * nw);
        end else if (widx < 9 * nw) begin
            d.hit  = 1'b1;
            d.bank = BK_ALT;
            d.sub  = SUB_W'(widx - 7 * nw);
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_store.sv
module gpio_store
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int NW      = NUM_PINS / 32,
    localparam int NA      = 2 * NW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  bank_e                 bank,
    input  logic [SUB_W-1:0]      sub,
    input  logic [31:0]           wdata,
    output logic [NUM_PINS-1:0]   dir_q,
    output logic [NUM_PINS-1:0]   out_q,
    output logic [2*NUM_PINS-1:0] alt_q
);
    logic [31:0] dir_w [NW];
    logic [31:0] out_w [NW];
    logic [31:0] alt_w [NA];

    for (genvar w = 0; w < NW; w++) begin : g_pinword
        logic sel;
        assign sel = wr_en && (sub == SUB_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_w[w] <= '0;
                out_w[w] <= '0;
            end else if (sel) begin
                case (bank)
                    BK_DIR: dir_w[w] <= wdata;
                    BK_SET: out_w[w] <= out_w[w] | wdata;
                    BK_CLR: out_w[w] <= out_w[w] & ~wdata;
                    default: ;
                endcase
            end
        end

        assign dir_q[w*32 +: 32] = dir_w[w];
        assign out_q[w*32 +: 32] = out_w[w];
    end

    for (genvar a = 0; a < NA; a++) begin : g_altword
        always_ff @(posedge clk) begin
            if (rst)
                alt_w[a] <= '0;
            else if (wr_en && bank == BK_ALT && sub == SUB_W'(a))
                alt_w[a] <= wdata;
        end
        assign alt_q[a*32 +: 32] = alt_w[a];
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int NW      = NUM_PINS / 32,
    localparam int NA      = 2 * NW
) (
    input  logic                  hit,
    input  bank_e                 bank,
    input  logic [SUB_W-1:0]      sub,
    input  logic [NUM_PINS-1:0]   level,
    input  logic [NUM_PINS-1:0]   dir,
    input  logic [2*NUM_PINS-1:0] alt,
    output logic [31:0]           rd_word
);
    always_comb begin
        rd_word = '0;
        if (hit) begin
            for (int w = 0; w < NW; w++) begin
                if (sub == SUB_W'(w)) begin
                    if (bank == BK_LEVEL) rd_word = level[w*32 +: 32];
                    if (bank == BK_DIR)   rd_word = dir[w*32 +: 32];
                end
            end
            for (int a = 0; a < NA; a++) begin
                if (bank == BK_ALT && sub == SUB_W'(a))
                    rd_word = alt[a*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] pin_alt
);
    localparam int NW = NUM_PINS / 32;

    dec_t             dec;
    logic             hit;
    logic [NUM_PINS-1:0] level;
    logic [31:0]      rd_word;
    logic [31:0]      rdata_q;

    always_comb begin
        dec = decode_word(int'(bus_addr[ADDR_W-1:2]), NW);
        hit = dec.hit && (bus_addr[1:0] == 2'b00);
    end

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (level)
    );

    gpio_store #(.NUM_PINS(NUM_PINS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_we && hit),
        .bank  (dec.bank),
        .sub   (dec.sub),
        .wdata (bus_wdata),
        .dir_q (pin_oe),
        .out_q (pin_out),
        .alt_q (pin_alt)
    );

    gpio_rd_mux #(.NUM_PINS(NUM_PINS)) u_rdmux (
        .hit     (hit),
        .bank    (dec.bank),
        .sub     (dec.sub),
        .level   (level),
        .dir     (pin_oe),
        .alt     (pin_alt),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [31:0]           bus_wdata,
    input logic [NUM_PINS-1:0]   pin_out,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic [2*NUM_PINS-1:0] pin_alt
);
    localparam int NW = NUM_PINS / 32;
    localparam logic [ADDR_W-1:0] A_DIR0  = ADDR_W'(1 * NW * 4);
    localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(2 * NW * 4);
    localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(3 * NW * 4);
    localparam logic [ADDR_W-1:0] A_RISE0 = ADDR_W'(4 * NW * 4);
    localparam logic [ADDR_W-1:0] A_ALT0  = ADDR_W'(7 * NW * 4);

    // R8: first cycle out of reset shows cleared pin state
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0 && pin_oe == '0 && pin_alt == '0));

    // R3: direction word 0 lands on pin_oe
    p_dir_word_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DIR0) |=> (pin_oe[31:0] == $past(bus_wdata)));

    // R4: ones set, zeros keep
    p_set_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET0) |=>
        ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    p_set_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET0) |=>
        ((pin_out[31:0] & ~$past(bus_wdata)) == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

    // R5: ones clear
    p_clr_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR0) |=> ((pin_out[31:0] & $past(bus_wdata)) == 32'h0));

    // R6: function-select word 0 lands on pin_alt
    p_alt_word_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ALT0) |=> (pin_alt[31:0] == $past(bus_wdata)));

    // R7: reserved bank write touches no pin port
    p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_RISE0) |=>
        ($stable(pin_out) && $stable(pin_oe) && $stable(pin_alt)));

    // R9: ports hold without a write
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && !$past(rst)) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_alt)));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_alt   (pin_alt)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
    localparam int NP = 64;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [2*NP-1:0] pin_alt;

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt)
    );

    localparam int SRC_RD = 0, SRC_OUT = 1, SRC_OE = 2, SRC_ALT = 3;

    typedef struct {
        int          due;
        int          src;
        int          word;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] probe(int src, int word);
        case (src)
            SRC_RD:  return bus_rdata;
            SRC_OUT: return pin_out[word*32 +: 32];
            SRC_OE:  return pin_oe[word*32 +: 32];
            default: return pin_alt[word*32 +: 32];
        endcase
    endfunction

    // monitor: pop entries that fall due and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = probe(it.src, it.word);
            n_run++;
            if (it.due < cyc) begin
                n_fail++;
                $display("FAIL %s src%0d word%0d missed due cycle: actual %h expected %h",
                         it.req, it.src, it.word, act, it.exp);
            end else if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s src%0d word%0d: actual %h expected %h",
                         it.req, it.src, it.word, act, it.exp);
            end
        end
    end

    function automatic logic [AW-1:0] addr_of(int bank, int word);
        return AW'((bank * (NP / 32) + word) * 4);
    endfunction

    task automatic expect_at(int src, int word, logic [31:0] exp, int dly, string req);
        item_t it;
        it.due = cyc + dly; it.src = src; it.word = word; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string req);
        bus_addr = a; bus_we = 1'b0;
        expect_at(SRC_RD, 0, exp, 1, req);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        expect_at(SRC_OE, 0, 32'h0, 1, "R8");
        expect_at(SRC_OUT, 1, 32'h0, 1, "R8");
        for (int a = 0; a < 4; a++) expect_at(SRC_ALT, a, 32'h0, 1, "R8");
        rd(addr_of(1, 0), 32'h0, "R8");

        // R3, R1, R9: direction words
        expect_at(SRC_OE, 0, 32'hA5A5_0F0F, 1, "R3 R9");
        wr(addr_of(1, 0), 32'hA5A5_0F0F);
        expect_at(SRC_OE, 1, 32'h1234_5678, 1, "R3");
        wr(addr_of(1, 1), 32'h1234_5678);
        rd(addr_of(1, 1), 32'h1234_5678, "R1 R3");
        rd(addr_of(1, 0), 32'hA5A5_0F0F, "R3");

        // R4: set
        expect_at(SRC_OUT, 0, 32'h0000_00FF, 1, "R4 R9");
        wr(addr_of(2, 0), 32'h0000_00FF);
        expect_at(SRC_OUT, 0, 32'hF000_00FF, 1, "R4");
        wr(addr_of(2, 0), 32'hF000_0000);
        rd(addr_of(2, 0), 32'h0, "R4");
        expect_at(SRC_OUT, 1, 32'h8000_0001, 1, "R4");
        wr(addr_of(2, 1), 32'h8000_0001);

        // R5: clear
        expect_at(SRC_OUT, 0, 32'hF000_00F0, 1, "R5");
        wr(addr_of(3, 0), 32'h0000_000F);
        expect_at(SRC_OUT, 1, 32'h8000_0001, 1, "R5");
        rd(addr_of(3, 1), 32'h0, "R5");

        // R2: level after synchroniser
        pin_in = 64'hDEAD_BEEF_CAFE_F00D;
        bus_addr = addr_of(0, 0);
        expect_at(SRC_RD, 0, 32'h0, 2, "R2");
        expect_at(SRC_RD, 0, 32'hCAFE_F00D, 3, "R2");
        repeat (3) @(negedge clk);
        rd(addr_of(0, 1), 32'hDEAD_BEEF, "R2");
        expect_at(SRC_OE, 0, 32'hA5A5_0F0F, 1, "R2");
        wr(addr_of(0, 0), 32'h0);
        rd(addr_of(0, 0), 32'hCAFE_F00D, "R2");

        // R6: function select
        expect_at(SRC_ALT, 1, 32'h0000_000E, 1, "R6");
        wr(addr_of(7, 1), 32'h0000_000E);
        expect_at(SRC_ALT, 3, 32'hC000_0000, 1, "R6");
        wr(addr_of(7, 3), 32'hC000_0000);
        rd(addr_of(7, 1), 32'h0000_000E, "R6");
        rd(addr_of(7, 3), 32'hC000_0000, "R6");
        expect_at(SRC_ALT, 0, 32'h0, 1, "R6");
        rd(addr_of(7, 0), 32'h0, "R6");

        // R7: reserved, past end, misaligned
        expect_at(SRC_OUT, 0, 32'hF000_00F0, 1, "R7");
        wr(addr_of(4, 0), 32'hFFFF_FFFF);
        rd(addr_of(4, 0), 32'h0, "R7");
        wr(addr_of(6, 1), 32'hFFFF_FFFF);
        rd(addr_of(6, 1), 32'h0, "R7");
        expect_at(SRC_OE, 0, 32'hA5A5_0F0F, 1, "R7");
        wr(addr_of(9, 0), 32'hFFFF_FFFF);
        rd(addr_of(9, 0), 32'h0, "R7");
        expect_at(SRC_OE, 0, 32'hA5A5_0F0F, 1, "R7");
        wr(addr_of(1, 0) + AW'(1), 32'h0);
        rd(addr_of(1, 0) + AW'(2), 32'h0, "R7");
        rd(addr_of(1, 0), 32'hA5A5_0F0F, "R7");

        // R8: reset again clears
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_at(SRC_OUT, 0, 32'h0, 0, "R8");
        expect_at(SRC_ALT, 3, 32'h0, 0, "R8");
        rd(addr_of(1, 0), 32'h0, "R8");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 %0d expectations never compared: actual %0d expected 0", q.size(), q.size());
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule